// File: doc/BRIEF.md
# AXI Burst Memory Slave with Programmable Responses

This block is an AXI slave that serves write and read bursts from an internal byte-wide memory. It is meant as a stress target in a verification environment. A write burst stores the bytes whose strobe bits are set. A read burst returns the bytes at each beat address. The write path (address, data and response channels) and the read path (address and data channels) are run by two separate state machines, so traffic on both paths can overlap.

Two plain inputs set the response code for writes and for reads. A byte-wide side port loads memory directly between or during transactions. When throttling is enabled, the address and write-data ready signals are gated by bits of a free-running 16-bit LFSR whose seed is a parameter. The master therefore sees irregular handshake timing.

The memory holds `2**MEM_AW` bytes and is indexed by the low `MEM_AW` address bits, so upper address bits alias. Write FSM: `WS_IDLE` goes to `WS_DATA` on the aw_take transition (AW handshake). `WS_DATA` goes to `WS_RESP` on w_final (handshake of beat number AWLEN). `WS_RESP` goes to `WS_IDLE` on b_take (B handshake). Read FSM: `RS_IDLE` goes to `RS_BURST` on ar_take (AR handshake). `RS_BURST` goes to `RS_IDLE` on r_final (handshake of the beat with RLAST).

Top module: `axi_mem_slave`

## Requirements
- R1: After reset, BVALID and RVALID are low.
- R2: Every strobed byte of a full-width INCR write burst is stored at the beat address. A later read of the same addresses returns those bytes. A burst carries LEN+1 beats, and WLAST is high on beat LEN.
- R3: A byte whose WSTRB bit is 0 keeps its previous memory contents.
- R4: In a FIXED burst (burst code 00), every beat uses the start address.
- R5: In a WRAP burst (burst code 10), the address wraps to the start of the block of (LEN+1)*2^SIZE bytes that contains the start address. LEN is 1, 3, 7 or 15.
- R6: In an INCR burst (burst code 01) with a SIZE below the bus width, the lanes of a beat are those of its address. After an unaligned first beat, the address steps from the SIZE-aligned start.
- R7: BID equals the AWID of the burst. BVALID rises the cycle after the final write beat is accepted. RID equals the ARID of the burst.
- R8: RLAST is high only on beat LEN of a read burst. RVALID is low in the cycle after that beat is accepted.
- R9: BRESP and RRESP take the configured codes (00 OKAY, 01 EXOKAY, 10 SLVERR, 11 DECERR). These codes are sampled when the address is accepted, so later changes do not affect a burst already in flight.
- R10: A side-port write puts cfg_wdata into the byte at cfg_addr. A later AXI read returns that byte.
- R11: While BVALID or RVALID is high and its ready input is low, the valid signal stays high and its ID, response and last flag stay unchanged.
- R12: A read burst completes while a write burst is between address acceptance and its data.
- R13: AWREADY is low from AW acceptance until the write response completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Side-port byte write enable |
| cfg_addr | input | ADDR_W | Side-port byte address |
| cfg_wdata | input | 8 | Side-port byte data |
| cfg_wr_resp | input | 2 | Response code for writes |
| cfg_rd_resp | input | 2 | Response code for reads |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awid | input | ID_W | Write ID |
| s_awaddr | input | ADDR_W | Write start address |
| s_awlen | input | 4 | Write beats minus one |
| s_awsize | input | 3 | Log2 bytes per write beat |
| s_awburst | input | 2 | Write burst type |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wlast | input | 1 | Final write beat |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_arid | input | ID_W | Read ID |
| s_araddr | input | ADDR_W | Read start address |
| s_arlen | input | 4 | Read beats minus one |
| s_arsize | input | 3 | Log2 bytes per read beat |
| s_arburst | input | 2 | Read burst type |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rid | output | ID_W | Read data ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Final read beat |

## Verification
An address handshake at one rising edge makes the data channel ready from the next cycle; RVALID and the first read word appear one cycle after AR is accepted. BVALID rises one cycle after the final write beat is taken, read data follows the memory combinationally at the current beat address, and a side-port byte is readable from the cycle after its write. The bench drives inputs and samples outputs on falling edges only and waits on the ready or valid it depends on, so the random throttling never shifts a check. Read beats are compared lane by lane against a byte model whose beat addresses are computed arithmetically from start, length, size and burst type.

// File: rtl/axi_mem_pkg.sv
package axi_mem_pkg;

    localparam logic [1:0] BT_FIXED = 2'b00;
    localparam logic [1:0] BT_INCR  = 2'b01;
    localparam logic [1:0] BT_WRAP  = 2'b10;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_EXOKAY = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    typedef enum logic [1:0] {
        WS_IDLE = 2'b00,
        WS_DATA = 2'b01,
        WS_RESP = 2'b10
    } wr_state_e;

    typedef enum logic {
        RS_IDLE  = 1'b0,
        RS_BURST = 1'b1
    } rd_state_e;

endpackage

// File: rtl/amem_lfsr.sv
module amem_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_aw,
    output logic gate_w,
    output logic gate_ar
);
    logic [15:0] shreg_q;
    logic        feedback;

    always_comb begin
        feedback = shreg_q[15] ^ shreg_q[13] ^ shreg_q[12] ^ shreg_q[10];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shreg_q <= SEED;
        else        shreg_q <= {shreg_q[14:0], feedback};
    end

    always_comb begin
        gate_aw = shreg_q[0];
        gate_w  = shreg_q[7];
        gate_ar = shreg_q[12];
    end
endmodule

// File: rtl/amem_addr_gen.sv
module amem_addr_gen
    import axi_mem_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [3:0]        len,
    input  logic [2:0]        size,
    input  logic [1:0]        burst,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] incr;
    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] wrapped;

    always_comb begin
        step      = ADDR_W'(1) << size;
        aligned   = cur_addr & ~(step - ADDR_W'(1));
        incr      = aligned + step;
        span_mask = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
        wrapped   = (cur_addr & ~span_mask) | (incr & span_mask);
        case (burst)
            BT_FIXED: next_addr = cur_addr;
            BT_WRAP:  next_addr = wrapped;
            default:  next_addr = incr;
        endcase
    end
endmodule

// File: rtl/amem_wr_fsm.sv
module amem_wr_fsm
    import axi_mem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_aw,
    input  logic              gate_w,
    input  logic [1:0]        resp_cfg,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ID_W-1:0]   awid,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic [3:0]        awlen,
    input  logic [2:0]        awsize,
    input  logic [1:0]        awburst,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wlast,
    output logic              bvalid,
    input  logic              bready,
    output logic [ID_W-1:0]   bid,
    output logic [1:0]        bresp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_wstrb
);
    wr_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nx;
    logic [3:0]        len_q;
    logic [3:0]        beat_q;
    logic [2:0]        size_q;
    logic [1:0]        burst_q;
    logic [1:0]        resp_q;
    logic              aw_take;
    logic              w_take;

    amem_addr_gen #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr (addr_q),
        .len      (len_q),
        .size     (size_q),
        .burst    (burst_q),
        .next_addr(addr_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (aw_take) state_d = WS_DATA;
            WS_DATA: if (w_take && beat_q == len_q) state_d = WS_RESP;
            WS_RESP: if (bready) state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        awready   = (state_q == WS_IDLE) && gate_aw;
        wready    = (state_q == WS_DATA) && gate_w;
        bvalid    = (state_q == WS_RESP);
        bid       = id_q;
        bresp     = resp_q;
        aw_take   = awvalid && awready;
        w_take    = wvalid && wready;
        mem_we    = w_take;
        mem_addr  = addr_q;
        mem_wdata = wdata;
        mem_wstrb = wstrb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            beat_q  <= '0;
            size_q  <= '0;
            burst_q <= BT_INCR;
            resp_q  <= RESP_OKAY;
        end else if (aw_take) begin
            id_q    <= awid;
            addr_q  <= awaddr;
            len_q   <= awlen;
            beat_q  <= '0;
            size_q  <= awsize;
            burst_q <= awburst;
            resp_q  <= resp_cfg;
        end else if (w_take) begin
            addr_q  <= addr_nx;
            beat_q  <= beat_q + 4'd1;
        end
    end

    assert_wlast_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready && wlast) |-> (beat_q == len_q));

    assert_b_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready && beat_q == len_q) |=> (bvalid && bid == $past(id_q)));

    assert_b_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));

    assert_aw_closed_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready) |=> (!awready && !bvalid));
endmodule

// File: rtl/amem_rd_fsm.sv
module amem_rd_fsm
    import axi_mem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_ar,
    input  logic [1:0]        resp_cfg,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [3:0]        arlen,
    input  logic [2:0]        arsize,
    input  logic [1:0]        arburst,
    output logic              rvalid,
    input  logic              rready,
    output logic [ID_W-1:0]   rid,
    output logic [1:0]        rresp,
    output logic              rlast,
    output logic [ADDR_W-1:0] mem_addr
);
    rd_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nx;
    logic [3:0]        len_q;
    logic [3:0]        beat_q;
    logic [2:0]        size_q;
    logic [1:0]        burst_q;
    logic [1:0]        resp_q;
    logic              ar_take;
    logic              r_take;

    amem_addr_gen #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr (addr_q),
        .len      (len_q),
        .size     (size_q),
        .burst    (burst_q),
        .next_addr(addr_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (ar_take) state_d = RS_BURST;
            RS_BURST: if (r_take && rlast) state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        arready  = (state_q == RS_IDLE) && gate_ar;
        rvalid   = (state_q == RS_BURST);
        rlast    = (state_q == RS_BURST) && (beat_q == len_q);
        rid      = id_q;
        rresp    = resp_q;
        ar_take  = arvalid && arready;
        r_take   = rvalid && rready;
        mem_addr = addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            beat_q  <= '0;
            size_q  <= '0;
            burst_q <= BT_INCR;
            resp_q  <= RESP_OKAY;
        end else if (ar_take) begin
            id_q    <= arid;
            addr_q  <= araddr;
            len_q   <= arlen;
            beat_q  <= '0;
            size_q  <= arsize;
            burst_q <= arburst;
            resp_q  <= resp_cfg;
        end else if (r_take) begin
            addr_q  <= addr_nx;
            beat_q  <= beat_q + 4'd1;
        end
    end

    assert_r_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && rlast) |=> !rvalid);

    assert_r_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rid) && $stable(rresp) && $stable(rlast)));

    assert_ar_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> (rvalid && rid == $past(arid)));
endmodule

// File: rtl/axi_mem_slave.sv
module axi_mem_slave
    import axi_mem_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 32,
    parameter int          ID_W      = 4,
    parameter int          MEM_AW    = 8,
    parameter bit          THROTTLE  = 1'b1,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [7:0]            cfg_wdata,
    input  logic [1:0]            cfg_wr_resp,
    input  logic [1:0]            cfg_rd_resp,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [ID_W-1:0]       s_awid,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic [3:0]            s_awlen,
    input  logic [2:0]            s_awsize,
    input  logic [1:0]            s_awburst,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    input  logic [DATA_W-1:0]     s_wdata,
    input  logic [DATA_W/8-1:0]   s_wstrb,
    input  logic                  s_wlast,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    output logic [ID_W-1:0]       s_bid,
    output logic [1:0]            s_bresp,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    input  logic [ID_W-1:0]       s_arid,
    input  logic [ADDR_W-1:0]     s_araddr,
    input  logic [3:0]            s_arlen,
    input  logic [2:0]            s_arsize,
    input  logic [1:0]            s_arburst,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    output logic [ID_W-1:0]       s_rid,
    output logic [DATA_W-1:0]     s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  s_rlast
);
    localparam int STRB_W    = DATA_W / 8;
    localparam int LANE_W    = $clog2(STRB_W);
    localparam int WIDX_W    = MEM_AW - LANE_W;
    localparam int MEM_BYTES = 1 << MEM_AW;

    logic              gate_aw, gate_w, gate_ar;
    logic              wr_we;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    logic [ADDR_W-1:0] rd_addr;
    logic [WIDX_W-1:0] wr_widx;
    logic [WIDX_W-1:0] rd_widx;
    logic [7:0]        mem [MEM_BYTES];

    generate
        if (THROTTLE) begin : g_throttle
            amem_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
                .clk    (clk),
                .rst_n  (rst_n),
                .gate_aw(gate_aw),
                .gate_w (gate_w),
                .gate_ar(gate_ar)
            );
        end else begin : g_open
            assign gate_aw = 1'b1;
            assign gate_w  = 1'b1;
            assign gate_ar = 1'b1;
        end
    endgenerate

    amem_wr_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .STRB_W(STRB_W)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_aw  (gate_aw),
        .gate_w   (gate_w),
        .resp_cfg (cfg_wr_resp),
        .awvalid  (s_awvalid),
        .awready  (s_awready),
        .awid     (s_awid),
        .awaddr   (s_awaddr),
        .awlen    (s_awlen),
        .awsize   (s_awsize),
        .awburst  (s_awburst),
        .wvalid   (s_wvalid),
        .wready   (s_wready),
        .wdata    (s_wdata),
        .wstrb    (s_wstrb),
        .wlast    (s_wlast),
        .bvalid   (s_bvalid),
        .bready   (s_bready),
        .bid      (s_bid),
        .bresp    (s_bresp),
        .mem_we   (wr_we),
        .mem_addr (wr_addr),
        .mem_wdata(wr_data),
        .mem_wstrb(wr_strb)
    );

    amem_rd_fsm #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_ar (gate_ar),
        .resp_cfg(cfg_rd_resp),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .arid    (s_arid),
        .araddr  (s_araddr),
        .arlen   (s_arlen),
        .arsize  (s_arsize),
        .arburst (s_arburst),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rid     (s_rid),
        .rresp   (s_rresp),
        .rlast   (s_rlast),
        .mem_addr(rd_addr)
    );

    always_comb begin
        wr_widx = WIDX_W'(wr_addr >> LANE_W);
        rd_widx = WIDX_W'(rd_addr >> LANE_W);
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < STRB_W; l++) begin
            if (wr_we && wr_strb[l]) mem[{wr_widx, LANE_W'(l)}] <= wr_data[l*8 +: 8];
        end
        if (cfg_we) mem[MEM_AW'(cfg_addr)] <= cfg_wdata;
    end

    generate
        for (genvar l = 0; l < STRB_W; l++) begin : g_lane
            assign s_rdata[l*8 +: 8] = mem[{rd_widx, LANE_W'(l)}];
        end
    endgenerate

    assert_rst_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!s_bvalid && !s_rvalid));
endmodule

// File: tb/axi_mem_slave_bench.sv
`timescale 1ns/1ps
module axi_mem_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [1:0]  cfg_wr_resp = 2'b00;
    logic [1:0]  cfg_rd_resp = 2'b00;
    logic        s_awvalid = 1'b0, s_awready;
    logic [3:0]  s_awid = '0;
    logic [15:0] s_awaddr = '0;
    logic [3:0]  s_awlen = '0;
    logic [2:0]  s_awsize = '0;
    logic [1:0]  s_awburst = '0;
    logic        s_wvalid = 1'b0, s_wready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wlast = 1'b0;
    logic        s_bvalid, s_bready = 1'b0;
    logic [3:0]  s_bid;
    logic [1:0]  s_bresp;
    logic        s_arvalid = 1'b0, s_arready;
    logic [3:0]  s_arid = '0;
    logic [15:0] s_araddr = '0;
    logic [3:0]  s_arlen = '0;
    logic [2:0]  s_arsize = '0;
    logic [1:0]  s_arburst = '0;
    logic        s_rvalid, s_rready = 1'b0;
    logic [3:0]  s_rid;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rlast;

    int n_total = 0;
    int n_bad = 0;
    int rcyc = 0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    axi_mem_slave u_axi_mem_slave (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int beat_addr(int start, int len, int size, int burst, int k);
        int nb = 1 << size;
        int total = (len + 1) * nb;
        if (burst == 0) return start;
        if (burst == 1) return (k == 0) ? start : (start - start % nb) + k * nb;
        return (start - start % total) + ((start % total) + k * nb) % total;
    endfunction

    function automatic logic [3:0] lanes(int a, int size);
        int nb = 1 << size;
        int lo = a % 4;
        int hi = (a - a % nb) % 4 + nb;
        logic [3:0] m = '0;
        for (int l = 0; l < 4; l++) if (l >= lo && l < hi) m[l] = 1'b1;
        return m;
    endfunction

    task automatic wr_aw(int id, int start, int len, int size, int burst);
        s_awid = 4'(id); s_awaddr = 16'(start); s_awlen = 4'(len);
        s_awsize = 3'(size); s_awburst = 2'(burst); s_awvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0;
    endtask

    task automatic wr_w(int start, int len, int size, int burst, int seed, logic [3:0] mask);
        for (int k = 0; k <= len; k++) begin
            int a = beat_addr(start, len, size, burst, k);
            logic [3:0] st = lanes(a, size) & mask;
            logic [31:0] d = 32'(seed * 32'h9E3779B1 + k * 32'h01030507 + 32'h1234567);
            for (int l = 0; l < 4; l++)
                if (st[l]) model[((a & ~3) + l) & 255] = d[l*8 +: 8];
            s_wdata = d; s_wstrb = st; s_wlast = (k == len); s_wvalid = 1'b1;
            while (!s_wready) @(negedge clk);
            @(negedge clk);
        end
        s_wvalid = 1'b0; s_wlast = 1'b0;
    endtask

    task automatic wr_b(int id, logic [1:0] exp_resp);
        s_bready = 1'b0;
        while (!s_bvalid) @(negedge clk);
        @(negedge clk);
        chk(s_bvalid, "R11", "bvalid held", 32'(s_bvalid), 1);
        chk(s_bid == 4'(id), "R7", "bid", 32'(s_bid), 32'(id));
        chk(s_bresp == exp_resp, "R9", "bresp", 32'(s_bresp), 32'(exp_resp));
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        chk(!s_bvalid, "R13", "bvalid after take", 32'(s_bvalid), 0);
    endtask

    task automatic rd_burst(int id, int start, int len, int size, int burst,
                            logic [1:0] exp_resp, string req);
        int k = 0;
        s_arid = 4'(id); s_araddr = 16'(start); s_arlen = 4'(len);
        s_arsize = 3'(size); s_arburst = 2'(burst); s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        while (k <= len) begin
            s_rready = (rcyc % 3) != 2;
            rcyc++;
            if (s_rvalid && s_rready) begin
                int a = beat_addr(start, len, size, burst, k);
                logic [3:0] m = lanes(a, size);
                logic [31:0] bm = '0, e = '0;
                for (int l = 0; l < 4; l++) begin
                    e[l*8 +: 8] = model[((a & ~3) + l) & 255];
                    if (m[l]) bm[l*8 +: 8] = 8'hFF;
                end
                chk((s_rdata & bm) == (e & bm), req, "rdata", s_rdata & bm, e & bm);
                chk(s_rid == 4'(id), "R7", "rid", 32'(s_rid), 32'(id));
                chk(s_rresp == exp_resp, "R9", "rresp", 32'(s_rresp), 32'(exp_resp));
                chk(s_rlast == (k == len), "R8", "rlast", 32'(s_rlast), 32'(k == len));
                k++;
            end
            @(negedge clk);
        end
        s_rready = 1'b0;
        chk(!s_rvalid, "R8", "rvalid after last", 32'(s_rvalid), 0);
    endtask

    task automatic side_write(int a, logic [7:0] d);
        cfg_addr = 16'(a); cfg_wdata = d; cfg_we = 1'b1;
        model[a & 255] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int idx = 0;
        int lens[5] = '{0, 1, 3, 7, 15};
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // preload through the side port so model and memory agree
        for (int i = 0; i < 256; i++) begin
            cfg_addr = 16'(i); cfg_wdata = 8'(i * 7 + 3); cfg_we = 1'b1;
            model[i] = 8'(i * 7 + 3);
            @(negedge clk);
        end
        cfg_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_bvalid, "R1", "bvalid after reset", 32'(s_bvalid), 0);
        chk(!s_rvalid, "R1", "rvalid after reset", 32'(s_rvalid), 0);

        // sweep: burst type x size x length
        for (int b = 0; b < 3; b++)
            for (int s = 0; s < 3; s++)
                for (int li = 0; li < 5; li++) begin
                    int len = lens[li];
                    int start = 16'h1200 + ((idx * 53 + 7) & 255);
                    string req;
                    if (b == 2 && len == 0) continue;
                    if (b == 2) start = start & ~((1 << s) - 1);
                    req = (b == 0) ? "R4" : (b == 2) ? "R5" : (s < 2) ? "R6" : "R2";
                    wr_aw(idx % 16, start, len, s, b);
                    wr_w(start, len, s, b, idx, 4'hF);
                    wr_b(idx % 16, 2'b00);
                    rd_burst((idx + 3) % 16, start, len, s, b, 2'b00, req);
                    idx++;
                end

        // R3: cleared strobes leave bytes alone
        wr_aw(1, 16'h0040, 3, 2, 1); wr_w(16'h0040, 3, 2, 1, 100, 4'hF); wr_b(1, 2'b00);
        wr_aw(2, 16'h0040, 3, 2, 1); wr_w(16'h0040, 3, 2, 1, 200, 4'b0101); wr_b(2, 2'b00);
        rd_burst(3, 16'h0040, 3, 2, 1, 2'b00, "R3");

        // R9: response codes latched at address acceptance
        cfg_wr_resp = 2'b10;
        wr_aw(4, 16'h0060, 1, 2, 1);
        cfg_wr_resp = 2'b00;
        wr_w(16'h0060, 1, 2, 1, 300, 4'hF); wr_b(4, 2'b10);
        cfg_wr_resp = 2'b01;
        wr_aw(5, 16'h0068, 0, 2, 1); wr_w(16'h0068, 0, 2, 1, 301, 4'hF); wr_b(5, 2'b01);
        cfg_wr_resp = 2'b00;
        cfg_rd_resp = 2'b11;
        rd_burst(6, 16'h0060, 1, 2, 1, 2'b11, "R9");
        cfg_rd_resp = 2'b00;

        // R10: side-port load visible to reads
        for (int i = 0; i < 8; i++) side_write(16'h1080 + i, 8'(8'hC0 + i));
        rd_burst(7, 16'h1080, 1, 2, 1, 2'b00, "R10");

        // R12: read runs while a write waits for its data
        wr_aw(8, 16'h00A0, 3, 2, 1);
        rd_burst(9, 16'h1080, 1, 2, 1, 2'b00, "R12");
        wr_w(16'h00A0, 3, 2, 1, 400, 4'hF);
        wr_b(8, 2'b00);
        rd_burst(10, 16'h00A0, 3, 2, 1, 2'b00, "R12");

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule